// File: doc/BRIEF.md
# Flash Array Erase-and-Verify Sequencer

This block is a host-side bus master that carries a byte-wide flash device through a full-array erase and then checks every byte. A one-cycle `start` pulse makes it pull chip-enable low and write the erase opcode 20h twice. The first write arms the erase and the second write launches it. The block then waits out the erase interval, measured from the rising write-strobe edge of the second 20h write. It then begins the verify pass. For each byte address it writes the verify opcode A0h with that address on the address pins, waits the settling interval from that write's rising strobe, and reads the byte back. An erased byte must read FFh.

The pass walks the addresses upward from zero. It stops at the first byte that is not FFh, and it reports that byte's address together with `fail`. If every byte reads FFh, it reports `pass` after the last address. All strobe widths and waits are whole clock cycles, derived from a clock-frequency parameter and nanosecond or microsecond parameters. The data bus is split into an output, an output enable and an input, so the pad ring can build the bidirectional pin. There is no streaming data path. Control and status are plain level and pulse pins.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset, before any `start`: `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `fl_dq_oe`, `busy`, `done`, `pass`, `fail` and `fail_addr` are 0.
- R2: After `start`, the first two bus writes carry 20h on `fl_dq_o`. Every later write in the run carries A0h.
- R3: The first A0h write's `fl_we_n` rising edge comes at least ERASE_US×CLK_MHZ cycles after the second 20h write's rising edge, and at most 64 cycles beyond that.
- R4: Each verify read starts (`fl_oe_n` falls) at least SETTLE_US×CLK_MHZ cycles after the rising edge of the preceding A0h write, and at most 16 cycles beyond that.
- R5: The k-th A0h write and the k-th read both drive address k on `fl_addr`, with k counting from 0.
- R6: If every byte reads FFh, the run ends with `done`=1, `pass`=1 and `fail`=0, after exactly 2^ADDR_W A0h writes and reads.
- R7: If byte k reads anything other than FFh, the run ends with `done`=1, `fail`=1, `pass`=0 and `fail_addr`=k, after exactly k+1 A0h writes. No bus write follows.
- R8: `fl_we_n` and `fl_oe_n` are never low together. `fl_dq_oe` is 0 whenever `fl_oe_n` is low, and chip-enable is low whenever either strobe is low.
- R9: Every `fl_we_n` low pulse lasts exactly ceil(CLK_MHZ×WE_NS/1000) cycles, which is 13 at 125 MHz with WE_NS=100. `fl_dq_o` is driven and stable throughout the pulse.
- R10: A `start` pulse while `busy` is 1 has no effect. The run's writes remain exactly as R2 to R7 describe.
- R11: `busy` rises on the cycle after an accepted `start` and `done` clears then. `done`, `pass`, `fail` and `fail_addr` then hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin erase and verify |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | All bytes read FFh |
| fail | output | 1 | A byte failed verification |
| fail_addr | output | ADDR_W | Address of the failing byte |
| fl_addr | output | ADDR_W | Flash address pins |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable (read strobe), active low |
| fl_we_n | output | 1 | Write enable (write strobe), active low |

## Verification
A bad sequencing state shows up on the flash pins within one bus cycle, as a write with the wrong opcode or address or as a missing or extra write. A timer loaded at the wrong moment shows up as a rising-edge-to-rising-edge or rising-edge-to-read gap that is too short, at the first A0h write or the first read. A broken address counter or compare shows up when `done` rises, as a wrong write count or a wrong `fail_addr`. The one exception is that a strobe overlap or a bus drive during a read is visible in the very cycle it happens.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERS_ARM,
    ST_ERS_FIRE,
    ST_ERS_WAIT,
    ST_VFY_WR,
    ST_SETTLE,
    ST_READ,
    ST_HALT
  } seq_state_t;

  typedef enum logic [1:0] {
    WP_IDLE,
    WP_SETUP,
    WP_PULSE,
    WP_HOLD
  } wr_phase_t;

  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_VERIFY   = 8'hA0;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // whole cycles covering a time in ns, never below one
  function automatic int ns_to_cyc(input int mhz, input int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/fes_interval.sv
module fes_interval #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             fire
);

  logic             run;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      left <= '0;
    end else if (load) begin
      run  <= 1'b1;
      left <= len - 1'b1;
    end else if (run && left == '0) begin
      run <= 1'b0;
    end else if (run) begin
      left <= left - 1'b1;
    end
  end

  // fires len cycles after the load edge
  assign fire = run && (left == '0);

endmodule

// File: rtl/fes_wr_cycle.sv
module fes_wr_cycle
  import fes_pkg::*;
#(
  parameter int SETUP_C = 7,
  parameter int PULSE_C = 13,
  parameter int HOLD_C  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] data,
  output logic       we_n,
  output logic       dq_oe,
  output logic [7:0] dq_o,
  output logic       rise,
  output logic       done
);

  localparam int MAXC = (SETUP_C > PULSE_C) ?
                        ((SETUP_C > HOLD_C) ? SETUP_C : HOLD_C) :
                        ((PULSE_C > HOLD_C) ? PULSE_C : HOLD_C);
  localparam int CW = $clog2(MAXC + 1);

  wr_phase_t       phase;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= WP_IDLE;
      cnt   <= '0;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      dq_o  <= '0;
    end else begin
      unique case (phase)
        WP_IDLE: begin
          if (go) begin
            dq_o  <= data;
            dq_oe <= 1'b1;
            cnt   <= CW'(SETUP_C - 1);
            phase <= WP_SETUP;
          end
        end
        WP_SETUP: begin
          if (cnt == '0) begin
            we_n  <= 1'b0;
            cnt   <= CW'(PULSE_C - 1);
            phase <= WP_PULSE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WP_PULSE: begin
          if (cnt == '0) begin
            we_n  <= 1'b1;
            cnt   <= CW'(HOLD_C - 1);
            phase <= WP_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WP_HOLD: begin
          if (cnt == '0) begin
            dq_oe <= 1'b0;
            phase <= WP_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= WP_IDLE;
      endcase
    end
  end

  // rise: the strobe goes high at the coming edge
  assign rise = (phase == WP_PULSE) && (cnt == '0);
  assign done = (phase == WP_HOLD) && (cnt == '0);

endmodule

// File: rtl/fes_rd_cycle.sv
module fes_rd_cycle #(
  parameter int ACC_C = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic oe_n,
  output logic done
);

  localparam int CW = $clog2(ACC_C + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      oe_n   <= 1'b1;
      cnt    <= '0;
    end else if (!active && go) begin
      active <= 1'b1;
      oe_n   <= 1'b0;
      cnt    <= CW'(ACC_C - 1);
    end else if (active && cnt == '0) begin
      active <= 1'b0;
      oe_n   <= 1'b1;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // last cycle of the access window: data is valid for compare
  assign done = active && (cnt == '0);

endmodule

// File: rtl/fes_addr_step.sv
module fes_addr_step #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (step)  addr <= addr + 1'b1;
  end

  assign at_last = &addr;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int CLK_MHZ   = 125,
  parameter int ERASE_US  = 10000,
  parameter int SETTLE_US = 6,
  parameter int WE_NS     = 100,
  parameter int SETUP_NS  = 50,
  parameter int HOLD_NS   = 50,
  parameter int ACCESS_NS = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int ERASE_CYC  = CLK_MHZ * ERASE_US;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int WE_CYC     = ns_to_cyc(CLK_MHZ, WE_NS);
  localparam int SETUP_CYC  = ns_to_cyc(CLK_MHZ, SETUP_NS);
  localparam int HOLD_CYC   = ns_to_cyc(CLK_MHZ, HOLD_NS);
  localparam int ACC_CYC    = ns_to_cyc(CLK_MHZ, ACCESS_NS);
  localparam int TMR_MAX    = (ERASE_CYC > SETTLE_CYC) ? ERASE_CYC : SETTLE_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  seq_state_t        state;
  logic              wr_go_q;
  logic [7:0]        wr_data_q;
  logic              rd_go_q;
  logic              wr_rise, wr_done, rd_done;
  logic              tmr_load, tmr_fire;
  logic [TMR_W-1:0]  tmr_len;
  logic [ADDR_W-1:0] addr;
  logic              at_last;
  logic              addr_clr, addr_step;
  logic              idle_like, byte_ok;

  assign idle_like = (state == ST_IDLE) || (state == ST_HALT);
  assign byte_ok   = (fl_dq_i == ERASED_BYTE);

  // wait timers start on the strobe's rising edge
  assign tmr_load = wr_rise && ((state == ST_ERS_FIRE) || (state == ST_VFY_WR));
  assign tmr_len  = (state == ST_ERS_FIRE) ? TMR_W'(ERASE_CYC) : TMR_W'(SETTLE_CYC);

  assign addr_clr  = idle_like && start;
  assign addr_step = (state == ST_READ) && rd_done && byte_ok && !at_last;

  fes_wr_cycle #(
    .SETUP_C (SETUP_CYC),
    .PULSE_C (WE_CYC),
    .HOLD_C  (HOLD_CYC)
  ) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (wr_go_q),
    .data  (wr_data_q),
    .we_n  (fl_we_n),
    .dq_oe (fl_dq_oe),
    .dq_o  (fl_dq_o),
    .rise  (wr_rise),
    .done  (wr_done)
  );

  fes_rd_cycle #(
    .ACC_C (ACC_CYC)
  ) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (rd_go_q),
    .oe_n  (fl_oe_n),
    .done  (rd_done)
  );

  fes_interval #(
    .CNT_W (TMR_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .fire  (tmr_fire)
  );

  fes_addr_step #(
    .AW (ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (addr_clr),
    .step    (addr_step),
    .addr    (addr),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_go_q   <= 1'b0;
      wr_data_q <= '0;
      rd_go_q   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      wr_go_q <= 1'b0;
      rd_go_q <= 1'b0;
      unique case (state)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            wr_go_q   <= 1'b1;
            wr_data_q <= OP_ERASE;
            state     <= ST_ERS_ARM;
          end
        end
        ST_ERS_ARM: begin
          if (wr_done) begin
            wr_go_q   <= 1'b1;
            wr_data_q <= OP_ERASE;
            state     <= ST_ERS_FIRE;
          end
        end
        ST_ERS_FIRE: begin
          if (wr_done) state <= ST_ERS_WAIT;
        end
        ST_ERS_WAIT: begin
          if (tmr_fire) begin
            wr_go_q   <= 1'b1;
            wr_data_q <= OP_VERIFY;
            state     <= ST_VFY_WR;
          end
        end
        ST_VFY_WR: begin
          if (wr_done) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_fire) begin
            rd_go_q <= 1'b1;
            state   <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_done) begin
            if (!byte_ok) begin
              fail      <= 1'b1;
              fail_addr <= addr;
              done      <= 1'b1;
              busy      <= 1'b0;
              state     <= ST_HALT;
            end else if (at_last) begin
              pass  <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_HALT;
            end else begin
              wr_go_q   <= 1'b1;
              wr_data_q <= OP_VERIFY;
              state     <= ST_VFY_WR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fl_ce_n = idle_like;
  assign fl_addr = ((state == ST_VFY_WR) || (state == ST_SETTLE) || (state == ST_READ))
                   ? addr : '0;

endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
  parameter int WE_C     = 13,
  parameter int ERASE_C  = 1000,
  parameter int SETTLE_C = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       ce_n,
  input logic       dq_oe,
  input logic [7:0] dq_o,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic       fail
);

  logic        we_q, oe_q;
  logic [31:0] low_cnt;
  logic [31:0] gap;
  logic [7:0]  last_op;
  logic        rise_now, oe_fall;

  assign rise_now = we_n && !we_q;
  assign oe_fall  = !oe_n && oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      low_cnt <= '0;
      gap     <= '0;
      last_op <= '0;
    end else begin
      we_q    <= we_n;
      oe_q    <= oe_n;
      low_cnt <= we_n ? '0 : low_cnt + 1;
      if (rise_now) begin
        gap     <= '0;
        last_op <= dq_o;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap <= gap + 1;
      end
    end
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  p_bus_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_chip_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !ce_n);

  p_we_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_now |-> (low_cnt == 32'(WE_C)));

  p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !we_q) |-> (dq_oe && $stable(dq_o)));

  p_erase_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && dq_o == 8'hA0 && last_op == 8'h20) |-> (gap >= 32'(ERASE_C)));

  p_settle_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_fall |-> (gap >= 32'(SETTLE_C)));

  p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind flash_erase_seq fes_chk #(
  .WE_C     (WE_CYC),
  .ERASE_C  (ERASE_CYC),
  .SETTLE_C (SETTLE_CYC)
) u_fes_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .we_n  (fl_we_n),
  .oe_n  (fl_oe_n),
  .ce_n  (fl_ce_n),
  .dq_oe (fl_dq_oe),
  .dq_o  (fl_dq_o),
  .busy  (busy),
  .done  (done),
  .pass  (pass),
  .fail  (fail)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int AW     = 4;
  localparam int NB     = 1 << AW;
  localparam int MHZ    = 125;
  localparam int ERS_US = 20;
  localparam int STL_US = 1;

  function automatic int cyc_of_ns(input int ns);
    return (MHZ * ns + 999) / 1000;
  endfunction

  localparam int EXP_ERASE  = MHZ * ERS_US;
  localparam int EXP_SETTLE = MHZ * STL_US;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, pass, fail;
  logic [AW-1:0] fail_addr, fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i;
  logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  logic [7:0] mem [0:NB-1];

  always #4 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W (AW), .CLK_MHZ (MHZ), .ERASE_US (ERS_US), .SETTLE_US (STL_US)
  ) u_flash_erase_seq (
    .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
    .pass (pass), .fail (fail), .fail_addr (fail_addr), .fl_addr (fl_addr),
    .fl_dq_o (fl_dq_o), .fl_dq_oe (fl_dq_oe), .fl_dq_i (fl_dq_i),
    .fl_ce_n (fl_ce_n), .fl_oe_n (fl_oe_n), .fl_we_n (fl_we_n)
  );

  assign fl_dq_i = !fl_oe_n ? mem[fl_addr] : 8'h00;

  // bus monitor, sampled at the falling edge
  int         cyc = 0;
  int         n_cmd, n_rd, bad_we, overlap, float_err, wcnt;
  logic [7:0] cmd_op  [0:63];
  int         cmd_adr [0:63];
  int         cmd_t   [0:63];
  int         rd_adr  [0:63];
  int         rd_t    [0:63];
  logic       we_prev = 1'b1, oe_prev = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (fl_we_n && !we_prev) begin
      if (n_cmd < 64) begin
        cmd_op[n_cmd]  <= fl_dq_o;
        cmd_adr[n_cmd] <= int'(fl_addr);
        cmd_t[n_cmd]   <= cyc;
      end
      n_cmd <= n_cmd + 1;
      if (wcnt != cyc_of_ns(100)) bad_we <= bad_we + 1;
    end
    wcnt <= fl_we_n ? 0 : wcnt + 1;
    if (!fl_oe_n && oe_prev) begin
      if (n_rd < 64) begin
        rd_adr[n_rd] <= int'(fl_addr);
        rd_t[n_rd]   <= cyc;
      end
      n_rd <= n_rd + 1;
    end
    if (!fl_we_n && !fl_oe_n) overlap <= overlap + 1;
    if (!fl_oe_n && fl_dq_oe) float_err <= float_err + 1;
    we_prev <= fl_we_n;
    oe_prev <= fl_oe_n;
  end

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_run(input int bad, input bit poke);
    int exp_a0, t, seq_err, adr_err, stl_err, gap, held;
    n_cmd = 0; n_rd = 0; bad_we = 0; overlap = 0; float_err = 0;
    for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
    if (bad >= 0) mem[bad] = 8'($urandom % 255);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done, "R11 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (!done && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R6 run finished", int'(done), 1);
    exp_a0 = (bad < 0) ? NB : bad + 1;
    chk(n_cmd == 2 + exp_a0, "R10 write count", n_cmd, 2 + exp_a0);
    chk(cmd_op[0] == 8'h20 && cmd_op[1] == 8'h20, "R2 erase opcodes",
        int'(cmd_op[1]), 32'h20);
    seq_err = 0; adr_err = 0; stl_err = 0;
    for (int k = 0; k < exp_a0 && k < 60; k++) begin
      if (cmd_op[2+k] != 8'hA0) seq_err++;
      if (cmd_adr[2+k] != k || rd_adr[k] != k) adr_err++;
      gap = rd_t[k] - cmd_t[2+k];
      if (gap < EXP_SETTLE || gap > EXP_SETTLE + 16) stl_err++;
    end
    chk(seq_err == 0, "R2 verify opcodes", seq_err, 0);
    chk(adr_err == 0, "R5 verify addresses", adr_err, 0);
    chk(n_rd == exp_a0, "R5 read count", n_rd, exp_a0);
    chk(stl_err == 0, "R4 settle gap", stl_err, 0);
    gap = cmd_t[2] - cmd_t[1];
    chk(gap >= EXP_ERASE && gap <= EXP_ERASE + 64, "R3 erase gap", gap, EXP_ERASE);
    if (bad < 0) begin
      chk(pass && !fail, "R6 pass verdict", int'(pass), 1);
    end else begin
      chk(fail && !pass, "R7 fail verdict", int'(fail), 1);
      chk(int'(fail_addr) == bad, "R7 fail address", int'(fail_addr), bad);
    end
    chk(overlap == 0 && float_err == 0, "R8 strobe and bus", overlap + float_err, 0);
    chk(bad_we == 0, "R9 strobe width", bad_we, 0);
    held = n_cmd;
    repeat (60) @(negedge clk);
    chk(n_cmd == held && done && !busy, "R11 result held, R7 no writes", n_cmd, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle in reset", 0, 1);
    chk(!fl_dq_oe && !busy && !done && !pass && !fail && fail_addr == '0,
        "R1 status in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done, "R1 idle after reset", 0, 1);
    do_run(-1, 1'b1);
    do_run(0, 1'b0);
    do_run(NB - 1, 1'b0);
    for (int r = 0; r < 4; r++) begin
      b = (($urandom % 3) == 0) ? -1 : int'($urandom % NB);
      do_run(b, r[0]);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule